// File: doc/BRIEF.md
# Serial Audio Bit and Frame Clock Generator

This block produces the bit clock and the frame clock of a serial audio port from an oversampling master clock. In master mode it divides the master clock with two coded ratios: master-clock cycles per frame and bit clocks per frame. It shapes the frame clock according to a format code. In slave mode it passes externally supplied bit and frame clocks through. Each of the four possible clocks (bit and frame, master and slave) has its own polarity control.

A frame-start strobe lasting one master-clock cycle marks the beginning of every frame. Software writes the ratio and format fields while the clock is stopped, then sets the clock enable. Ratio and format changes made while the clock runs wait for the next frame boundary.

Top module: `audio_frame_clkgen`

## Requirements
- R1: `ratio_cfg[14:12]` selects the master-clock cycles per frame M: code 0=512, 1=256, 2=128, 3=64, 4=32. In master mode one frame lasts max(M, 2B) master-clock cycles.
- R2: `ratio_cfg[10:8]` selects the bit clocks per frame B: code 0=32, 1=64, 2=128, 3=256, 4=512, 7=16. Each bit clock half period lasts H = max(1, M/(2B)) master-clock cycles. Each bit starts with the low half of the unpolarised bit clock.
- R3: Codes 5, 6 and 7 in the M field behave as code 0 (512). Codes 5 and 6 in the B field behave as code 0 (32).
- R4: The master select is `ratio_cfg[0]` when `dir_capture`=0 and `ratio_cfg[4]` when `dir_capture`=1. When the selected bit is clear, `bclk` and `fclk` follow `ext_bclk` and `ext_fclk`.
- R5: `pol_cfg` inverts the clocks. Bit 12 inverts the master frame clock, bit 8 the master bit clock, bit 4 the slave frame clock and bit 0 the slave bit clock. Polarity and the master select act immediately.
- R6: `fmt_cfg[6:4]` selects the frame clock shape, where p is the bit position in the frame. Codes 0 and 1 (mono) drive the frame clock high for p < B/2. Code 2 (PCM) drives it high for p = 0 only. Code 3 (I2S) drives it high for p >= B/2. Codes 6 and 7 behave as code 0.
- R7: Codes 4 and 5 (TDM) take the channel count C = `fmt_cfg[2:0]`+1. The frame clock is high for the first B >> ceil(log2 C) bits.
- R8: In the delayed codes 1, 3 and 5, p is taken one bit ahead, (bit+1) mod B. Every frame clock edge therefore comes one bit clock before the data bit it marks.
- R9: While `clk_en` is low in master mode, generation stops. `bclk` and `fclk` equal their master polarity bits, no frame start is flagged, and the configuration is sampled each cycle. The first enabled cycle begins bit 0 of a frame.
- R10: In master mode `frame_start` is high for exactly the first master-clock cycle of each frame.
- R11: Ratio and format changes made while the clock runs take effect from the first cycle of the next frame.
- R12: In slave mode with `clk_en` high, `frame_start` is high for one cycle when the polarity-corrected external frame clock rises. It stays low while `clk_en` is low.
- R13: During and right after reset with all inputs zero, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock generation enable |
| dir_capture | input | 1 | Selects which direction's master bit applies |
| ratio_cfg | input | 16 | Ratio codes and master-select bits |
| pol_cfg | input | 16 | Polarity inversion bits |
| fmt_cfg | input | 8 | Format code and TDM channel count minus one |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fclk | input | 1 | External frame clock (slave mode) |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| frame_start | output | 1 | One-cycle frame-start strobe |

## Verification
The hardest situation to reach is a configuration change that arrives mid-frame while the clock runs. The old timing must finish the current frame while the new polarity already applies. A directed run starts a short I2S frame and, partway through, switches to a longer TDM frame with inverted polarity. It then compares every cycle across the boundary. Seeded random configurations, including the reserved codes, cover the ratio, format and delay combinations cycle by cycle over two frames.

// File: rtl/audio_frame_clkgen.sv
`timescale 1ns/1ps
module audio_frame_clkgen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clk_en,
  input  logic        dir_capture,
  input  logic [15:0] ratio_cfg,
  input  logic [15:0] pol_cfg,
  input  logic [7:0]  fmt_cfg,
  input  logic        ext_bclk,
  input  logic        ext_fclk,
  output logic        bclk,
  output logic        fclk,
  output logic        frame_start
);
  localparam int HCW = 4;
  localparam int BCW = 9;
  localparam int CFW = 12;

  logic [CFW-1:0] act, nxt;
  logic [2:0] mc, bc, fc, cc;
  logic mst, go;
  logic [3:0] lg_m, lg_b;
  logic [2:0] hsh;
  logic [HCW-1:0] hlast, hcnt;
  logic [BCW:0] nbits, slot, half;
  logic [BCW-1:0] blast, bcnt, pos;
  logic ph, fprev, hwrap, bend, fwrap, dly, fi;
  logic [1:0] clg;
  logic fclk_s, bclk_s;
  logic unused_bits;

  assign nxt = {ratio_cfg[14:12], ratio_cfg[10:8], fmt_cfg[6:4], fmt_cfg[2:0]};
  assign {mc, bc, fc, cc} = act;
  assign mst = dir_capture ? ratio_cfg[4] : ratio_cfg[0];
  assign go  = mst & clk_en;
  assign unused_bits = ^{ratio_cfg[15], ratio_cfg[11], ratio_cfg[7:5], ratio_cfg[3:1],
                         pol_cfg[15:13], pol_cfg[11:9], pol_cfg[7:5], pol_cfg[3:1],
                         fmt_cfg[7], fmt_cfg[3]};

  assign lg_m  = (mc <= 3'd4) ? (4'd9 - {1'b0, mc}) : 4'd9;
  assign lg_b  = (bc == 3'd7) ? 4'd4 : (bc <= 3'd4) ? (4'd5 + {1'b0, bc}) : 4'd5;
  assign hsh   = (lg_m > lg_b + 4'd1) ? 3'(lg_m - lg_b - 4'd1) : 3'd0;
  assign hlast = HCW'((5'd1 << hsh) - 5'd1);
  assign nbits = (BCW+1)'(1) << lg_b;
  assign blast = BCW'(nbits - (BCW+1)'(1));
  assign half  = nbits >> 1;

  assign hwrap = (hcnt == hlast);
  assign bend  = hwrap & ph;
  assign fwrap = bend & (bcnt == blast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      ph    <= 1'b0;
      bcnt  <= '0;
      act   <= '0;
      fprev <= 1'b0;
    end else begin
      fprev <= fclk_s;
      if (!go) begin
        hcnt <= '0;
        ph   <= 1'b0;
        bcnt <= '0;
        act  <= nxt;
      end else begin
        hcnt <= hwrap ? '0 : hcnt + 1'b1;
        if (hwrap) ph <= ~ph;
        if (bend) bcnt <= fwrap ? '0 : bcnt + 1'b1;
        if (fwrap) act <= nxt;
      end
    end
  end

  assign dly = (fc == 3'd1) || (fc == 3'd3) || (fc == 3'd5);
  assign pos = !dly ? bcnt : ((bcnt == blast) ? '0 : bcnt + 1'b1);

  always_comb begin
    case (cc)
      3'd0:       clg = 2'd0;
      3'd1:       clg = 2'd1;
      3'd2, 3'd3: clg = 2'd2;
      default:    clg = 2'd3;
    endcase
  end
  assign slot = nbits >> clg;

  always_comb begin
    case (fc)
      3'd2:       fi = (pos == '0);
      3'd3:       fi = ({1'b0, pos} >= half);
      3'd4, 3'd5: fi = ({1'b0, pos} < slot);
      default:    fi = ({1'b0, pos} < half);
    endcase
  end

  assign fclk_s = ext_fclk ^ pol_cfg[4];
  assign bclk_s = ext_bclk ^ pol_cfg[0];

  assign bclk = mst ? ((go & ph) ^ pol_cfg[8]) : bclk_s;
  assign fclk = mst ? ((go & fi) ^ pol_cfg[12]) : fclk_s;
  assign frame_start = mst ? (go & ~ph & (hcnt == '0) & (bcnt == '0))
                           : (clk_en & fclk_s & ~fprev);

  // R10
  fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && frame_start) |=> !(go && frame_start));

  // R2
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go) && hcnt != '0) |-> $stable(ph));

  // R9
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (hcnt == '0 && !ph && bcnt == '0));

  // R1
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> hcnt <= hlast);

  // R2
  bcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> {1'b0, bcnt} < nbits);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go) && !$past(fwrap)) |-> $stable(act));
endmodule

// File: tb/test_audio_frame_clkgen.sv
`timescale 1ns/1ps
module test_audio_frame_clkgen;
  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, dir_capture = 1'b0;
  logic ext_bclk = 1'b0, ext_fclk = 1'b0;
  logic [15:0] ratio_cfg = '0, pol_cfg = '0;
  logic [7:0] fmt_cfg = '0;
  logic bclk, fclk, frame_start;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  audio_frame_clkgen i_audio_frame_clkgen (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .dir_capture(dir_capture),
    .ratio_cfg(ratio_cfg), .pol_cfg(pol_cfg), .fmt_cfg(fmt_cfg),
    .ext_bclk(ext_bclk), .ext_fclk(ext_fclk),
    .bclk(bclk), .fclk(fclk), .frame_start(frame_start));

  task automatic chk(input bit ok, input string tag, input string what, input int g, input int e);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, g, e);
    end
  endtask

  // c = {inv_fm, inv_bm, inv_fs, inv_bs, mcode[3], bcode[3], fmt[3], ch[3]}
  function automatic int m_of(int mcode);
    return (mcode <= 4) ? (512 >> mcode) : 512;
  endfunction
  function automatic int b_of(int bcode);
    if (bcode == 7) return 16;
    if (bcode <= 4) return 32 << bcode;
    return 32;
  endfunction
  function automatic int h_of(logic [15:0] c);
    int h;
    h = m_of(int'(c[11:9])) / (2 * b_of(int'(c[8:6])));
    return (h < 1) ? 1 : h;
  endfunction
  function automatic int flen(logic [15:0] c);
    return 2 * h_of(c) * b_of(int'(c[8:6]));
  endfunction

  function automatic logic [2:0] model(int k, logic [15:0] c);
    int h, b, bit_i, p, f, nch, cl, slot;
    logic ph, fs, fi;
    h = h_of(c);
    b = b_of(int'(c[8:6]));
    bit_i = (k / (2 * h)) % b;
    ph = ((k / h) % 2) == 1;
    fs = (k % (2 * h * b)) == 0;
    f = int'(c[5:3]);
    if (f > 5) f = 0;
    p = (f == 1 || f == 3 || f == 5) ? (bit_i + 1) % b : bit_i;
    nch = int'(c[2:0]) + 1;
    cl = (nch == 1) ? 0 : (nch == 2) ? 1 : (nch <= 4) ? 2 : 3;
    slot = b >> cl;
    case (f)
      2:       fi = (p == 0);
      3:       fi = (p >= b / 2);
      4, 5:    fi = (p < slot);
      default: fi = (p < b / 2);
    endcase
    return {ph ^ c[14], fi ^ c[15], fs};
  endfunction

  task automatic set_cfg(input logic [15:0] c, input bit dc);
    ratio_cfg = {1'b0, c[11:9], 1'b0, c[8:6], 3'b0, dc, 3'b0, ~dc};
    pol_cfg   = {3'b0, c[15], 3'b0, c[14], 3'b0, c[13], 3'b0, c[12]};
    fmt_cfg   = {1'b0, c[5:3], 1'b0, c[2:0]};
  endtask

  task automatic run_cfg(input logic [15:0] ca, input logic [15:0] cb, input int chg,
                         input int n, input bit dc, input string tag);
    int la;
    logic [2:0] got, exp;
    @(negedge clk);
    clk_en = 1'b0;
    dir_capture = dc;
    set_cfg(ca, dc);
    @(negedge clk);
    clk_en = 1'b1;
    la = flen(ca);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (chg >= 0 && k == chg) set_cfg(cb, dc);
      #1;
      if (chg < 0 || k < la)
        exp = model(k, (chg >= 0 && k >= chg) ? {cb[15:12], ca[11:0]} : ca);
      else
        exp = model(k - la, cb);
      got = {bclk, fclk, frame_start};
      chk(got == exp, tag, "bclk/fclk/frame_start", int'(got), int'(exp));
    end
    @(negedge clk);
    clk_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] c;
    void'($urandom(32'd2024));
    // R13 reset state
    repeat (3) @(negedge clk);
    #1 chk({bclk, fclk, frame_start} == 3'b000, "R13", "outs in reset", int'({bclk, fclk, frame_start}), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk); #1;
    chk({bclk, fclk, frame_start} == 3'b000, "R13", "outs after reset", int'({bclk, fclk, frame_start}), 0);

    // R9 stopped master shows polarity only
    @(negedge clk);
    set_cfg({4'b1100, 3'd4, 3'd7, 3'd0, 3'd0}, 1'b0);
    clk_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk({bclk, fclk, frame_start} == 3'b110, "R9", "stopped outs", int'({bclk, fclk, frame_start}), 6);
    end

    // R1 R3 R2 reserved code fallback and large ratio
    run_cfg({4'b0000, 3'd5, 3'd5, 3'd0, 3'd0}, '0, -1, 520, 1'b0, "R3 R1");
    run_cfg({4'b1010, 3'd6, 3'd6, 3'd2, 3'd0}, '0, -1, 200, 1'b1, "R3 R5");
    run_cfg({4'b0100, 3'd7, 3'd7, 3'd3, 3'd0}, '0, -1, 80, 1'b0, "R3 R2 R8");

    // R7 R8 delayed TDM with five channels
    run_cfg({4'b0000, 3'd4, 3'd7, 3'd5, 3'd4}, '0, -1, 70, 1'b0, "R7 R8");
    // R6 PCM and reserved format
    run_cfg({4'b0000, 3'd3, 3'd0, 3'd2, 3'd0}, '0, -1, 130, 1'b0, "R6");
    run_cfg({4'b0000, 3'd4, 3'd7, 3'd7, 3'd0}, '0, -1, 66, 1'b1, "R6");

    // R11 mid-frame change: I2S 32-cycle frame, then TDM 64-cycle frame with inverted polarity
    run_cfg({4'b0000, 3'd4, 3'd7, 3'd3, 3'd0}, {4'b1100, 3'd3, 3'd0, 3'd4, 3'd3}, 10, 160, 1'b0, "R11 R5");

    // Random configurations
    for (int r = 0; r < 24; r++) begin
      c = 16'($urandom);
      run_cfg(c, '0, -1, 2 * flen(c) + 3, 1'($urandom), "R1 R2 R3 R5 R6 R7 R8 R10");
    end

    // R4 wrong-direction select bit leaves the port in slave mode
    @(negedge clk);
    dir_capture = 1'b1;
    ratio_cfg = 16'h0001;
    pol_cfg = '0;
    ext_bclk = 1'b1;
    ext_fclk = 1'b0;
    clk_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk({bclk, fclk} == 2'b10, "R4", "slave follow", int'({bclk, fclk}), 2);
    end

    // R12 R5 slave strobe with slave inversions
    @(negedge clk);
    dir_capture = 1'b0;
    ratio_cfg = 16'h0000;
    pol_cfg = 16'h0011;
    ext_fclk = 1'b1;
    ext_bclk = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk({bclk, fclk, frame_start} == 3'b100, "R12 R5", "slave idle", int'({bclk, fclk, frame_start}), 4);
    end
    @(negedge clk);
    ext_fclk = 1'b0;
    #1 chk({fclk, frame_start} == 2'b11, "R12", "slave strobe", int'({fclk, frame_start}), 3);
    @(negedge clk); #1;
    chk({fclk, frame_start} == 2'b10, "R12", "slave strobe end", int'({fclk, frame_start}), 2);
    @(negedge clk) ext_fclk = 1'b1;
    @(negedge clk) clk_en = 1'b0;
    @(negedge clk);
    ext_fclk = 1'b0;
    #1 chk(frame_start == 1'b0, "R12", "slave strobe disabled", int'(frame_start), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule